// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Selectable Output Latency

This block is a synchronous static RAM of `2**ADDR_W` words, each `NUM_BYTES` lanes of `BYTE_W` bits (64-bit words by default). Setting `ADDR_W` to 16 gives a 65,536-word array; the default is smaller so the array stays light when elaborated. All address, control and write-data inputs are sampled on the rising clock edge, and at most one access (a read or a write) is performed per edge. A strobe loads a start address. The advance input then walks a 2-bit beat counter through the other three words of an aligned group of four. The walk is either interleaved (the low address bits are XORed with the beat number) or linear (the beat number is added modulo 4).

Writes update any subset of byte lanes through per-lane strobes that count only while a lane-write enable is high. A global write stores all lanes at once. Read data leaves on a stream of `rd_valid` and `rdata`. In flow-through mode a word appears after one edge; in pipelined mode it appears after two, so back-to-back bursts keep one word per cycle. The read stream has no ready input and no back-pressure: the consumer must take each beat in the cycle in which `rd_valid` is high. When `rd_valid` is low, `rdata` is zero. The output enable acts on `rdata` without a clock. A snooze input turns every edge it covers into a no-operation. A strobe seen while any chip select is low deselects the device and cancels the burst and any read still in flight.

Top module: `burst_sram`

## Requirements
- R1: A strobe with `wr_all` high stores all of `wdata` at `addr`. A later read of that word returns it, and the write edge itself produces no read beat.
- R2: With `byte_wr_en` high and `wr_all` low, bit i of `byte_we` updates bits `[BYTE_W*i +: BYTE_W]` and leaves the other lanes unchanged. With `byte_wr_en` low, `byte_we` is ignored and the access is a read.
- R3: `wr_all` high writes every lane, whatever `byte_wr_en` and `byte_we` hold.
- R4: A rising edge with `strb_a` or `strb_b` high and all three selects high performs an access at `addr` and sets the beat count to 0. Each later edge with `adv` high and no strobe adds 1 to the 2-bit beat count, wrapping from 3 to 0, and performs an access at the resulting address. Address bits above bit 1 keep the start value.
- R5: With `lin_mode` = 0, the low two address bits of beat k are the start low bits XOR k.
- R6: With `lin_mode` = 1, the low two address bits of beat k are (start low bits + k) mod 4.
- R7: With `flow_mode` = 1, a read performed at edge E gives `rd_valid` = 1 and its word on `rdata` from edge E until edge E+1.
- R8: With `flow_mode` = 0, a read performed at edge E appears from edge E+1 until edge E+2.
- R9: `oe` low forces `rdata` to zero at once. It changes neither `rd_valid` nor the burst position.
- R10: An edge with `snooze` high performs no access. It ignores strobes, advance and writes, and leaves the burst position unchanged.
- R11: A strobe while any of `sel_a`, `sel_b`, `sel_c` is low performs no access and ends the burst, so later advances do nothing. A pipelined read still in flight is dropped, and `rd_valid` is low after that edge.
- R12: An edge with no strobe and no advance performs no access and keeps the burst position.
- R13: In pipelined mode, a strobe, three advances, a second strobe and three advances on eight consecutive edges give eight consecutive valid beats: the first word arrives on the third cycle and every later word one cycle apart.
- R14: `rdata` is zero whenever `rd_valid` is low, including right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | Word address loaded by a strobe |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| strb_a | input | 1 | Address strobe, loads a new burst |
| strb_b | input | 1 | Second address strobe, same effect |
| adv | input | 1 | Advance to the next beat of the burst |
| wr_all | input | 1 | Global write of all lanes |
| byte_wr_en | input | 1 | Enables the per-lane write strobes |
| byte_we | input | NUM_BYTES | Per-lane write strobes |
| wdata | input | NUM_BYTES*BYTE_W | Write data |
| oe | input | 1 | Output enable, unclocked |
| lin_mode | input | 1 | 1 = linear beat order, 0 = interleaved |
| flow_mode | input | 1 | 1 = flow-through output, 0 = pipelined |
| snooze | input | 1 | Low-power hold; no access while high |
| rdata | output | NUM_BYTES*BYTE_W | Read data stream |
| rd_valid | output | 1 | Read data valid |

## Verification
The bench builds the block with `ADDR_W` = 8 and eight 8-bit lanes. Every word can therefore be preloaded with a unique pattern, so a beat fetched out of order or from the wrong group of four shows up as a data mismatch. The small array also leaves room to run both beat orders, the wrap past the fourth beat, lane-masked writes and back-to-back pipelined bursts in both latency modes inside a short run. Snooze, deselect and output-enable events are placed in the middle of bursts, where a wrong hold or a wrong cancel changes the words the scoreboard expects.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef logic [1:0] beat_t;

  // Low address bits for a beat: linear adds, interleaved XORs.
  function automatic beat_t beat_lsb(input beat_t base, input beat_t idx, input logic linear);
    return linear ? beat_t'(base + idx) : (base ^ idx);
  endfunction
endpackage

// File: rtl/burst_sram_seq.sv
module burst_sram_seq
  import burst_sram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          linear,
  input  logic [AW-1:0] start,
  output logic [AW-1:0] acc_addr
);
  logic [AW-1:0] base_q;
  beat_t         cnt_q;
  beat_t         cnt_nxt;

  assign cnt_nxt = cnt_q + 2'd1;

  always_comb begin
    if (load) acc_addr = start;
    else      acc_addr = {base_q[AW-1:2], beat_lsb(base_q[1:0], cnt_nxt, linear)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= start;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int AW = 8,
  parameter int NB = 8,
  parameter int BW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [NB-1:0]    wr_mask,
  input  logic [AW-1:0]    addr,
  input  logic [NB*BW-1:0] wdata,
  output logic [NB*BW-1:0] q,
  output logic             q_vld
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [BW-1:0] lane_mem [DEPTH];
    logic [BW-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (wr_mask[b]) lane_mem[addr] <= wdata[b*BW +: BW];
      if (rd_en)      lane_q         <= lane_mem[addr];
    end

    assign q[b*BW +: BW] = lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= rd_en;
  end
endmodule

// File: rtl/burst_sram_outq.sv
module burst_sram_outq #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flow,
  input  logic          kill,
  input  logic [DW-1:0] in_q,
  input  logic          in_vld,
  output logic [DW-1:0] out_q,
  output logic          out_vld
);
  logic [DW-1:0] s2_q;
  logic          s2_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= in_vld & ~kill;
  end

  always_ff @(posedge clk) begin
    if (in_vld) s2_q <= in_q;
  end

  assign out_q   = flow ? in_q   : s2_q;
  assign out_vld = flow ? in_vld : s2_v;
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 8,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        sel_a,
  input  logic                        sel_b,
  input  logic                        sel_c,
  input  logic                        strb_a,
  input  logic                        strb_b,
  input  logic                        adv,
  input  logic                        wr_all,
  input  logic                        byte_wr_en,
  input  logic [NUM_BYTES-1:0]        byte_we,
  input  logic [NUM_BYTES*BYTE_W-1:0] wdata,
  input  logic                        oe,
  input  logic                        lin_mode,
  input  logic                        flow_mode,
  input  logic                        snooze,
  output logic [NUM_BYTES*BYTE_W-1:0] rdata,
  output logic                        rd_valid
);
  localparam int DATA_W = NUM_BYTES * BYTE_W;

  logic                 selected, strobe, awake;
  logic                 load, desel, step, acc_en, active_q;
  logic [NUM_BYTES-1:0] lane_mask, wr_mask;
  logic                 is_write, rd_en;
  logic [ADDR_W-1:0]    acc_addr;
  logic [DATA_W-1:0]    arr_q, out_q;
  logic                 arr_vld, out_vld;

  assign selected = sel_a & sel_b & sel_c;
  assign strobe   = strb_a | strb_b;
  assign awake    = ~snooze;
  assign load     = awake & strobe & selected;
  assign desel    = awake & strobe & ~selected;
  assign step     = awake & ~strobe & adv & active_q;
  assign acc_en   = load | step;

  assign lane_mask = wr_all ? '1 : (byte_wr_en ? byte_we : '0);
  assign is_write  = |lane_mask;
  assign wr_mask   = acc_en ? lane_mask : '0;
  assign rd_en     = acc_en & ~is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              active_q <= 1'b0;
    else if (awake & strobe) active_q <= selected;
  end

  burst_sram_seq #(.AW(ADDR_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .linear   (lin_mode),
    .start    (addr),
    .acc_addr (acc_addr)
  );

  burst_sram_array #(.AW(ADDR_W), .NB(NUM_BYTES), .BW(BYTE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_mask (wr_mask),
    .addr    (acc_addr),
    .wdata   (wdata),
    .q       (arr_q),
    .q_vld   (arr_vld)
  );

  burst_sram_outq #(.DW(DATA_W)) u_outq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flow    (flow_mode),
    .kill    (desel),
    .in_q    (arr_q),
    .in_vld  (arr_vld),
    .out_q   (out_q),
    .out_vld (out_vld)
  );

  assign rd_valid = out_vld;
  assign rdata    = (oe & out_vld) ? out_q : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int NB = 8,
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_a,
  input logic          sel_b,
  input logic          sel_c,
  input logic          strb_a,
  input logic          strb_b,
  input logic          adv,
  input logic          wr_all,
  input logic          byte_wr_en,
  input logic [NB-1:0] byte_we,
  input logic          oe,
  input logic          flow_mode,
  input logic          snooze,
  input logic [DW-1:0] rdata,
  input logic          rd_valid
);
  logic any_strb, all_sel, wr_req;
  assign any_strb = strb_a | strb_b;
  assign all_sel  = sel_a & sel_b & sel_c;
  assign wr_req   = wr_all | (byte_wr_en & (|byte_we));

  // R14
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rdata == '0);

  // R9
  oe_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> rdata == '0);

  // R10
  snooze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snooze && flow_mode) |=> (!rd_valid || !flow_mode));

  // R11
  desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && any_strb && !all_sel) |=> !rd_valid);

  // R12
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && !any_strb && !adv && flow_mode) |=> (!rd_valid || !flow_mode));

  // R1
  write_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snooze && any_strb && all_sel && wr_req && flow_mode) |=> (!rd_valid || !flow_mode));
endmodule

bind burst_sram burst_sram_chk #(.NB(NUM_BYTES), .DW(NUM_BYTES*BYTE_W)) u_chk (.*);

// File: tb/test_burst_sram.sv
`timescale 1ns/1ps
module test_burst_sram;
  localparam int AW = 8;
  localparam int NB = 8;
  localparam int DW = NB * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          sel_a = 1'b1, sel_b = 1'b1, sel_c = 1'b1;
  logic          strb_a = 1'b0, strb_b = 1'b0, adv = 1'b0;
  logic          wr_all = 1'b0, byte_wr_en = 1'b0;
  logic [NB-1:0] byte_we = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe = 1'b1, lin_mode = 1'b0, flow_mode = 1'b1, snooze = 1'b0;
  logic [DW-1:0] rdata;
  logic          rd_valid;

  burst_sram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(8)) i_burst_sram (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    int            cyc;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  logic [DW-1:0] ref_mem [1 << AW];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic          m_act = 1'b0;
  int            cyc = 0;
  int            checks = 0;
  int            failures = 0;
  bit            done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Driver: model one edge from the requirements, queue any expected read beat.
  task automatic step(input string tag);
    logic          sel, str, acc;
    logic [AW-1:0] a;
    logic [NB-1:0] mask;
    sel = sel_a & sel_b & sel_c;
    str = strb_a | strb_b;
    acc = 1'b0;
    a   = '0;
    if (!snooze) begin
      if (str && sel) begin
        m_base = addr; m_cnt = 2'd0; m_act = 1'b1; acc = 1'b1; a = addr;
      end else if (str) begin
        m_act = 1'b0;
        while (sb.size() > 0 && sb[$].cyc >= cyc + 1) void'(sb.pop_back());
      end else if (adv && m_act) begin
        m_cnt = m_cnt + 2'd1;
        a = {m_base[AW-1:2], lin_mode ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
        acc = 1'b1;
      end
    end
    mask = wr_all ? '1 : (byte_wr_en ? byte_we : '0);
    if (acc) begin
      if (mask != '0) begin
        for (int b = 0; b < NB; b++)
          if (mask[b]) ref_mem[a][b*8 +: 8] = wdata[b*8 +: 8];
      end else begin
        sb.push_back('{cyc + 1 + (flow_mode ? 0 : 1), ref_mem[a], tag});
      end
    end
    @(negedge clk);
  endtask

  task automatic clr();
    strb_a = 0; strb_b = 0; adv = 0; wr_all = 0; byte_wr_en = 0; byte_we = '0;
    snooze = 0; sel_a = 1; sel_b = 1; sel_c = 1;
  endtask

  task automatic idle(input int n);
    clr();
    for (int i = 0; i < n; i++) step("R12");
  endtask

  task automatic rd_start(input logic [AW-1:0] a, input bit use_b, input string tag);
    clr(); addr = a;
    if (use_b) strb_b = 1; else strb_a = 1;
    step(tag);
  endtask

  task automatic advance(input int n, input string tag);
    clr(); adv = 1;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
    clr(); strb_a = 1; wr_all = 1; addr = a; wdata = d;
    step("R1");
  endtask

  // Monitor: pops and compares as beats appear.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        while (sb.size() > 0 && sb[0].cyc < cyc) begin
          exp_t m;
          m = sb.pop_front();
          chk(1'b0, {m.tag, " missing beat"}, '0, m.data);
        end
        if (sb.size() > 0 && sb[0].cyc == cyc) begin
          exp_t e;
          logic [DW-1:0] expd;
          e = sb.pop_front();
          expd = oe ? e.data : '0;
          chk(rd_valid === 1'b1, {e.tag, " valid"}, DW'(rd_valid), 1);
          chk(rdata === expd, {e.tag, " data"}, rdata, expd);
        end else begin
          chk(rd_valid === 1'b0, "R12 no beat expected", DW'(rd_valid), 0);
          chk(rdata === '0, "R14 idle data", rdata, '0);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R13 actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid === 1'b0 && rdata === '0, "R14 reset", rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 64; i++)
      wr_word(AW'(i), {8{8'(i)}} ^ 64'h0123_4567_89AB_CDEF);

    rd_start(8'd5, 1'b1, "R7");
    idle(1);
    // interleaved order from low bits 01: 13,12,15,14
    rd_start(8'd13, 1'b0, "R5");
    advance(3, "R5");
    idle(2);
    lin_mode = 1'b1;
    idle(1);
    // linear order from low bits 01: 13,14,15,12
    rd_start(8'd13, 1'b1, "R6");
    advance(3, "R6");
    // wrap after the fourth beat
    rd_start(8'd18, 1'b0, "R4");
    advance(5, "R4");
    // gaps inside a burst
    rd_start(8'd21, 1'b0, "R12");
    idle(2);
    advance(2, "R12");
    idle(1);

    // lane writes
    clr(); strb_a = 1; addr = 8'd3; byte_wr_en = 1; byte_we = 8'h0F; wdata = '1; step("R2");
    rd_start(8'd3, 1'b0, "R2");
    clr(); strb_a = 1; addr = 8'd3; byte_wr_en = 0; byte_we = 8'hFF; wdata = '0; step("R2");
    clr(); strb_b = 1; addr = 8'd7; byte_wr_en = 1; byte_we = 8'hA0; wdata = 64'hFEDC_BA98_7654_3210; step("R2");
    rd_start(8'd7, 1'b1, "R2");
    clr(); strb_a = 1; addr = 8'd9; wr_all = 1; byte_wr_en = 1; byte_we = 8'h01;
    wdata = 64'hDEAD_BEEF_CAFE_F00D; step("R3");
    rd_start(8'd9, 1'b0, "R3");

    // burst write then burst read
    clr(); strb_a = 1; addr = 8'd42; wr_all = 1; wdata = 64'h1111_0000_0000_0042; step("R4");
    for (int i = 1; i < 4; i++) begin
      clr(); adv = 1; wr_all = 1; wdata = 64'h2222_0000_0000_0000 + DW'(i); step("R4");
    end
    lin_mode = 1'b0;
    rd_start(8'd40, 1'b0, "R4");
    advance(3, "R4");

    // snooze mid-burst
    rd_start(8'd8, 1'b0, "R10");
    clr(); snooze = 1; adv = 1; step("R10");
    clr(); snooze = 1; strb_a = 1; addr = 8'd50; wr_all = 1; wdata = '0; step("R10");
    advance(2, "R10");
    rd_start(8'd50, 1'b1, "R10");

    // output enable low mid-burst
    oe = 1'b0;
    rd_start(8'd16, 1'b0, "R9");
    advance(1, "R9");
    oe = 1'b1;
    advance(2, "R9");

    // deselect in flow-through mode
    rd_start(8'd28, 1'b0, "R11");
    clr(); strb_b = 1; sel_c = 0; addr = 8'd33; step("R11");
    advance(2, "R11");
    idle(2);

    // pipelined mode
    flow_mode = 1'b0;
    idle(2);
    rd_start(8'd11, 1'b0, "R8");
    idle(3);
    rd_start(8'd24, 1'b0, "R13");
    advance(3, "R13");
    rd_start(8'd29, 1'b1, "R13");
    advance(3, "R13");
    idle(3);
    rd_start(8'd30, 1'b0, "R11");
    clr(); strb_a = 1; sel_b = 0; addr = 8'd31; step("R11");
    advance(2, "R11");
    idle(3);
    flow_mode = 1'b1;
    idle(3);

    chk(sb.size() == 0, "R7 scoreboard drained", DW'(sb.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule